// File: doc/BRIEF.md
# Square Clear and Diagonal Line Plotter

This block produces a stream of pixel writes for a frame buffer that lives outside it. A single-cycle start request makes it first paint a square region, 120 pixels wide and 120 pixels tall, in colour 0. It then draws a 45-degree line in colour 1, starting at x = 0, y = 100 and ending at x = 100, y = 0. Each write appears as a coordinate pair and a colour, qualified by a plot strobe. The frame buffer takes one write on every cycle in which plot is high.

The design keeps its storage and arithmetic apart from its sequencing. A datapath module holds the x and y coordinate registers, an incrementer for each register, a decrementer for y, and the compare logic. A controller state machine steps through idle, clear, line set-up, line and finished. It drives the datapath's clear, load, increment and decrement controls. A thin top module connects the two.

Only lines of exact unit slope are produced: in every step x rises by one and y falls by one. The line ends when the incremented x equals 101. At that point y is held at 0, so it never wraps.

Top module: `diag_plotter`

## Requirements
- R1: While reset is high, and on the first cycle after it is released, plot and done are 0 and x and y are 0.
- R2: A start pulse seen in the idle state causes the clear sweep to begin on the next cycle. The sweep writes one pixel per cycle in colour 0, with x running fastest from 0 to 119 and y advancing from 0 to 119, for 14400 writes.
- R3: After the last clear write there is exactly one cycle with plot low. The first line write, at (0,100) in colour 1, follows on the next cycle.
- R4: In the line phase, each write has x one higher and y one lower than the write before it. The last write is at (100,0), for 101 line writes.
- R5: Plot is high only on write cycles. Within each phase it stays high on consecutive cycles, so one run produces exactly 14501 writes.
- R6: Done goes high on the cycle after the last line write. It stays high, with plot low, until a start pulse is seen.
- R7: A start pulse that arrives during the clear or line phase has no effect on the sequence of writes or on their timing.
- R8: A start pulse seen while done is high clears done and begins a complete new run, with the same timing as a run started from idle.
- R9: The colour output is 0 during clear writes and 1 during line writes. Its upper two bits are always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all registers update on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Run request; it is acted on only when the block is idle or done |
| x | output | 8 | Column of the current pixel |
| y | output | 7 | Row of the current pixel |
| colour | output | 3 | Colour of the current pixel |
| plot | output | 1 | High on each cycle that carries a pixel write |
| done | output | 1 | High from the end of a run until the next start |

## Verification
The hardest behaviour to reach from the ports is the single cycle between the two phases. It cannot be observed directly, because plot is simply low on that cycle. The scoreboard therefore tags every expected write with the exact cycle on which it must appear, counted from the start pulse. An extra write or a missing gap then shows up as a cycle mismatch. A stray start pulse is injected in the middle of the clear sweep. A second run is then launched from the done state, and its timing is checked against the same predicted schedule.

// File: rtl/diag_plotter.sv
module plot_datapath #(
  parameter int X_W   = 8,
  parameter int Y_W   = 7,
  parameter int CLR_W = 120,
  parameter int CLR_H = 120,
  parameter int LN_Y0 = 100
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           x_clr,
  input  logic           x_inc,
  input  logic           y_clr,
  input  logic           y_inc,
  input  logic           y_dec,
  input  logic           y_load,
  output logic [X_W-1:0] x,
  output logic [Y_W-1:0] y,
  output logic           x_last,
  output logic           y_last,
  output logic           x_hit_end
);
  localparam logic [X_W-1:0] X_LAST = X_W'(CLR_W - 1);
  localparam logic [Y_W-1:0] Y_LAST = Y_W'(CLR_H - 1);
  localparam logic [X_W-1:0] X_END  = X_W'(LN_Y0 + 1);
  localparam logic [Y_W-1:0] Y_INIT = Y_W'(LN_Y0);

  logic [X_W-1:0] x_q, x_plus;
  logic [Y_W-1:0] y_q, y_plus, y_minus;

  assign x_plus    = x_q + 1'b1;
  assign y_plus    = y_q + 1'b1;
  assign y_minus   = y_q - 1'b1;
  assign x_last    = (x_q == X_LAST);
  assign y_last    = (y_q == Y_LAST);
  assign x_hit_end = (x_plus == X_END);

  always_ff @(posedge clk) begin
    if (rst)        x_q <= '0;
    else if (x_clr) x_q <= '0;
    else if (x_inc) x_q <= x_plus;
  end

  always_ff @(posedge clk) begin
    if (rst)         y_q <= '0;
    else if (y_clr)  y_q <= '0;
    else if (y_load) y_q <= Y_INIT;
    else if (y_inc)  y_q <= y_plus;
    else if (y_dec)  y_q <= y_minus;
  end

  assign x = x_q;
  assign y = y_q;
endmodule

module plot_ctrl (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       x_last,
  input  logic       y_last,
  input  logic       x_hit_end,
  output logic       x_clr,
  output logic       x_inc,
  output logic       y_clr,
  output logic       y_inc,
  output logic       y_dec,
  output logic       y_load,
  output logic [2:0] colour,
  output logic       plot,
  output logic       done
);
  typedef enum logic [2:0] {S_IDLE, S_CLEAR, S_LINIT, S_LINE, S_DONE} st_t;
  st_t st, st_nx;

  always_ff @(posedge clk) begin
    if (rst) st <= S_IDLE;
    else     st <= st_nx;
  end

  always_comb begin
    st_nx  = st;
    x_clr  = 1'b0;
    x_inc  = 1'b0;
    y_clr  = 1'b0;
    y_inc  = 1'b0;
    y_dec  = 1'b0;
    y_load = 1'b0;
    unique case (st)
      S_IDLE, S_DONE: if (start) begin
        x_clr = 1'b1;
        y_clr = 1'b1;
        st_nx = S_CLEAR;
      end
      S_CLEAR: if (x_last) begin
        x_clr = 1'b1;
        if (y_last) st_nx = S_LINIT;
        else        y_inc = 1'b1;
      end else begin
        x_inc = 1'b1;
      end
      S_LINIT: begin
        x_clr  = 1'b1;
        y_load = 1'b1;
        st_nx  = S_LINE;
      end
      S_LINE: begin
        x_inc = 1'b1;
        if (x_hit_end) st_nx = S_DONE;
        else           y_dec = 1'b1;
      end
      default: st_nx = S_IDLE;
    endcase
  end

  assign plot   = (st == S_CLEAR) || (st == S_LINE);
  assign colour = {2'b00, st == S_LINE};
  assign done   = (st == S_DONE);
endmodule

module diag_plotter (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  output logic [7:0] x,
  output logic [6:0] y,
  output logic [2:0] colour,
  output logic       plot,
  output logic       done
);
  logic x_clr, x_inc, y_clr, y_inc, y_dec, y_load;
  logic x_last, y_last, x_hit_end;

  plot_datapath #(.X_W(8), .Y_W(7), .CLR_W(120), .CLR_H(120), .LN_Y0(100)) u_dp (
    .clk(clk), .rst(rst),
    .x_clr(x_clr), .x_inc(x_inc),
    .y_clr(y_clr), .y_inc(y_inc), .y_dec(y_dec), .y_load(y_load),
    .x(x), .y(y),
    .x_last(x_last), .y_last(y_last), .x_hit_end(x_hit_end)
  );

  plot_ctrl u_ctrl (
    .clk(clk), .rst(rst), .start(start),
    .x_last(x_last), .y_last(y_last), .x_hit_end(x_hit_end),
    .x_clr(x_clr), .x_inc(x_inc),
    .y_clr(y_clr), .y_inc(y_inc), .y_dec(y_dec), .y_load(y_load),
    .colour(colour), .plot(plot), .done(done)
  );
endmodule

// File: rtl/diag_plotter_chk.sv
module diag_plotter_chk (
  input logic       clk,
  input logic       rst,
  input logic       start,
  input logic [7:0] x,
  input logic [6:0] y,
  input logic [2:0] colour,
  input logic       plot,
  input logic       done
);
  p_clear_in_square_r2: assert property (@(posedge clk) disable iff (rst)
    (plot && colour == 3'd0) |-> (x < 8'd120 && y < 7'd120));

  p_clear_raster_r2: assert property (@(posedge clk) disable iff (rst)
    (plot && colour == 3'd0 && $past(plot && colour == 3'd0) && x != 8'd0)
      |-> (x == $past(x) + 1'b1 && y == $past(y)));

  p_line_step_r4: assert property (@(posedge clk) disable iff (rst)
    (plot && colour == 3'd1 && $past(plot && colour == 3'd1))
      |-> (x == $past(x) + 1'b1 && y == $past(y) - 1'b1));

  p_line_bounds_r4: assert property (@(posedge clk) disable iff (rst)
    (plot && colour == 3'd1) |-> (x <= 8'd100 && y <= 7'd100));

  p_no_plot_when_done_r5: assert property (@(posedge clk) disable iff (rst)
    !(plot && done));

  p_done_holds_r6: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> done);

  p_done_drops_r8: assert property (@(posedge clk) disable iff (rst)
    (done && start) |=> (!done && plot && x == 8'd0 && y == 7'd0));

  p_colour_range_r9: assert property (@(posedge clk) disable iff (rst)
    colour[2:1] == 2'b00);
endmodule

bind diag_plotter diag_plotter_chk u_chk (
  .clk(clk), .rst(rst), .start(start), .x(x), .y(y),
  .colour(colour), .plot(plot), .done(done)
);

// File: tb/sim_diag_plotter.sv
module sim_diag_plotter;
  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [7:0] x;
  logic [6:0] y;
  logic [2:0] colour;
  logic plot, done;

  typedef struct { int cyc; int px; int py; int pc; string req; } item_t;
  item_t exp_q[$];
  int cyc = 0;
  int checks = 0, errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  diag_plotter u0 (.clk(clk), .rst(rst), .start(start), .x(x), .y(y),
                   .colour(colour), .plot(plot), .done(done));

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp_v);
    end
  endtask

  // monitor: pops one expected write for each plot cycle
  always @(negedge clk) begin
    if (!rst && plot) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R5", "unexpected write at cycle", cyc, -1);
      end else begin
        item_t it;
        it = exp_q.pop_front();
        if (cyc != it.cyc || int'(x) != it.px || int'(y) != it.py || int'(colour) != it.pc) begin
          errors++;
          $display("FAIL %s write actual cyc %0d (%0d,%0d) c%0d expected cyc %0d (%0d,%0d) c%0d",
                   it.req, cyc, x, y, colour, it.cyc, it.px, it.py, it.pc);
        end
        checks++;
      end
    end
  end

  // driver: pulses start at a negedge and predicts the whole schedule
  task automatic run_frame(input bit stray);
    int base;
    @(negedge clk);
    base = cyc + 1;
    for (int py = 0; py < 120; py++)
      for (int px = 0; px < 120; px++)
        exp_q.push_back('{base + py*120 + px, px, py, 0, "R2"});
    for (int j = 0; j <= 100; j++)
      exp_q.push_back('{base + 14401 + j, j, 100 - j, 1, (j == 0) ? "R3" : "R4"});
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (stray) begin
      repeat (500) @(negedge clk);
      start = 1'b1;   // R7: ignored mid-clear
      @(negedge clk);
      start = 1'b0;
      repeat (14000) @(negedge clk);
      start = 1'b1;   // R7: ignored mid-line
      @(negedge clk);
      start = 1'b0;
    end
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
    chk(done == 1'b1, "R6", "done after last write", done, 1);
    chk(plot == 1'b0, "R5", "plot after run", plot, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(plot == 1'b0 && done == 1'b0, "R1", "plot/done in reset", {plot, done}, 0);
    chk(x == 8'd0 && y == 7'd0, "R1", "x/y in reset", {x, y}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(plot == 1'b0 && done == 1'b0, "R1", "plot/done after reset", {plot, done}, 0);
    repeat (4) @(negedge clk);
    chk(plot == 1'b0, "R1", "idle without start", plot, 0);

    run_frame(1'b1);
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      chk(done == 1'b1 && plot == 1'b0, "R6", "done held", {done, plot}, 2);
    end
    chk(colour[2:1] == 2'b00, "R9", "colour upper bits", colour, 0);

    run_frame(1'b0);   // R8: restart from done
    chk(exp_q.size() == 0, "R8", "second run complete", exp_q.size(), 0);
    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired, queue %0d expected 0", exp_q.size());
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule